// File: doc/BRIEF.md
# Rounding Integer Square Root Unit

This unit takes an unsigned operand and returns its square root rounded to the nearest integer. It uses a non-restoring digit recurrence. Each iteration takes the next two operand bits, starting from the most significant pair, and produces one root bit. A negative partial remainder is never corrected. Instead, the following iteration adds where it would otherwise subtract. Once all integer bits are known, one more iteration works out the first bit after the binary point, and that bit decides whether the integer root is rounded up.

The operand width and the architecture are fixed when the unit is elaborated. The sequential build reuses one iteration stage over several clocks and accepts a new operand only when idle. The pipelined build unrolls every iteration into its own register stage and accepts one operand per clock. Both builds have the same latency and use only general logic and flip-flops. Operands enter through a valid/ready handshake. The root leaves with a valid flag and has no backpressure.

Top module: `isqrt_round`

## Requirements
- R1: `root_o` equals sqrt(`in_op`) rounded to the nearest integer. `root_o` is OP_W/2+1 bits wide. OP_W is even and at least 4.
- R2: An operand of 0 gives 0 and an operand of 1 gives 1. Operands 2, 3 and 4 give 1, 2 and 2.
- R3: The all-ones operand gives exactly 2^(OP_W/2), which is held in the top root bit. No valid result ever exceeds 2^(OP_W/2).
- R4: The architecture is chosen by ARCH: 0 selects sequential and 1 selects pipelined. In both builds, an operand accepted at rising edge k shows up as `out_valid`=1 with its root directly after edge k+OP_W/2.
- R5: In the pipelined build, `in_ready` is always high. A result comes out on every clock that follows a valid input by OP_W/2+1 edges, in acceptance order. Input gaps reappear as `out_valid`=0 cycles.
- R6: In the sequential build, `in_ready` drops after the accepting edge and stays low until the result cycle. `out_valid` is high for exactly one cycle, and `in_ready` is high again during that cycle.
- R7: In the sequential build, `in_valid` asserted while `in_ready` is low is ignored. It does not change the pending result and does not produce an extra result.
- R8: The active-low reset `rst_n` clears every valid flag, sets the sequential controller idle with `in_ready` high, and abandons any computation in progress.
- R9: Operands k*k+k round down to k, and operands k*k+k+1 round up to k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present on `in_op` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | OP_W | Unsigned operand |
| out_valid | output | 1 | `root_o` holds a result this cycle |
| root_o | output | OP_W/2+1 | Rounded square root |

## Verification
The bench builds two copies of the unit. One is the sequential core at OP_W=16, where every corner fits in 16-bit arithmetic, including 65535 rounding up to 256. The other is the pipelined core at OP_W=48, which reaches a 25-deep stage chain, the 2^24 carry-out on the all-ones operand, and the rounding boundaries next to 2^24. Both copies receive seeded random operands mixed with directed corner cases. The bench also pokes the sequential core while it is busy and resets it in the middle of a computation.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic {
    ARCH_SEQ  = 1'b0,
    ARCH_PIPE = 1'b1
  } isqrt_arch_e;
endpackage

// File: rtl/isqrt_step.sv
// One non-restoring iteration: shift two operand bits into the partial
// remainder, then subtract (remainder non-negative) or add (negative)
// the trial term built from the partial root, and append one root bit.
module isqrt_step #(
  parameter int QW = 9,
  parameter int RW = QW + 3
) (
  input  logic [RW-1:0] rem_i,
  input  logic [QW-1:0] root_i,
  input  logic [1:0]    pair_i,
  output logic [RW-1:0] rem_o,
  output logic [QW-1:0] root_o
);
  logic          neg;
  logic [RW-1:0] shifted;
  logic [RW-1:0] trial;

  always_comb begin
    neg     = rem_i[RW-1];
    shifted = {rem_i[RW-3:0], pair_i};
    trial   = {{(RW-QW-2){1'b0}}, root_i, neg, 1'b1};
    rem_o   = neg ? (shifted + trial) : (shifted - trial);
    root_o  = {root_i[QW-2:0], ~rem_o[RW-1]};
  end
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  output logic            out_valid,
  output logic [OP_W/2:0] root_raw
);
  localparam int N  = OP_W / 2;
  localparam int QW = N + 1;
  localparam int RW = N + 4;
  localparam int XW = OP_W + 2;
  localparam int CW = $clog2(N + 1) + 1;

  logic          busy_q, busy_d;
  logic          ov_q, ov_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rem_q, rem_d, st_rem_in, st_rem_out;
  logic [QW-1:0] q_q, q_d, st_q_in, st_q_out;
  logic [XW-1:0] opnd_q, opnd_d;
  logic [1:0]    st_pair;
  logic          accept, dp_en;

  assign accept = in_valid && !busy_q;
  assign dp_en  = accept || busy_q;

  always_comb begin
    st_rem_in = busy_q ? rem_q : '0;
    st_q_in   = busy_q ? q_q : '0;
    st_pair   = busy_q ? opnd_q[XW-1:XW-2] : in_op[OP_W-1:OP_W-2];
  end

  isqrt_step #(.QW(QW), .RW(RW)) step_i (
    .rem_i (st_rem_in),
    .root_i(st_q_in),
    .pair_i(st_pair),
    .rem_o (st_rem_out),
    .root_o(st_q_out)
  );

  // next-state process
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ov_d   = 1'b0;
    rem_d  = st_rem_out;
    q_d    = st_q_out;
    opnd_d = opnd_q << 2;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CW'(1);
      opnd_d = {in_op[OP_W-3:0], 4'b0000};
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(N)) begin
        busy_d = 1'b0;
        ov_d   = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ov_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ov_q   <= ov_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      rem_q  <= rem_d;
      q_q    <= q_d;
      opnd_q <= opnd_d;
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = ov_q;
  assign root_raw  = q_q;

  a_r6_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(N)));
endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  output logic            out_valid,
  output logic [OP_W/2:0] root_raw
);
  localparam int N  = OP_W / 2;
  localparam int QW = N + 1;
  localparam int RW = N + 4;
  localparam int XW = OP_W + 2;

  logic [RW-1:0] rin   [0:N];
  logic [QW-1:0] qin   [0:N];
  logic [XW-1:0] oin   [0:N];
  logic          vin   [0:N];
  logic [RW-1:0] rem_r [0:N];
  logic [QW-1:0] q_r   [0:N];
  logic          v_r   [0:N];

  assign rin[0] = '0;
  assign qin[0] = '0;
  assign oin[0] = {in_op, 2'b00};
  assign vin[0] = in_valid;

  for (genvar s = 0; s <= N; s++) begin : g_stage
    logic [RW-1:0] rem_nx;
    logic [QW-1:0] q_nx;

    if (s > 0) begin : g_link
      assign rin[s] = rem_r[s-1];
      assign qin[s] = q_r[s-1];
      assign vin[s] = v_r[s-1];
    end

    isqrt_step #(.QW(QW), .RW(RW)) step_i (
      .rem_i (rin[s]),
      .root_i(qin[s]),
      .pair_i(oin[s][XW-1:XW-2]),
      .rem_o (rem_nx),
      .root_o(q_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_r[s] <= 1'b0;
      else        v_r[s] <= vin[s];
    end

    always_ff @(posedge clk) begin
      if (vin[s]) begin
        rem_r[s] <= rem_nx;
        q_r[s]   <= q_nx;
      end
    end

    if (s < N) begin : g_opnd
      logic [XW-1:0] op_r;
      always_ff @(posedge clk) begin
        if (vin[s]) op_r <= oin[s] << 2;
      end
      assign oin[s+1] = op_r;
    end
  end

  assign in_ready  = 1'b1;
  assign out_valid = v_r[N];
  assign root_raw  = q_r[N];
endmodule

// File: rtl/isqrt_round.sv
module isqrt_round
  import isqrt_pkg::*;
#(
  parameter int          OP_W = 16,
  parameter isqrt_arch_e ARCH = ARCH_SEQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  output logic            out_valid,
  output logic [OP_W/2:0] root_o
);
  localparam int N  = OP_W / 2;
  localparam int QW = N + 1;

  logic [QW-1:0] raw;

  if (ARCH == ARCH_PIPE) begin : g_pipe
    isqrt_pipe #(.OP_W(OP_W)) core_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .out_valid(out_valid), .root_raw(raw)
    );
  end else begin : g_seq
    isqrt_seq #(.OP_W(OP_W)) core_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .out_valid(out_valid), .root_raw(raw)
    );
  end

  // raw = floor(2*sqrt(x)); the rounded root is (raw + 1) >> 1
  assign root_o = {1'b0, raw[QW-1:1]} + QW'(raw[0]);

  a_r3_root_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (root_o <= {1'b1, {N{1'b0}}}));
endmodule

// File: tb/isqrt_round_tb.sv
module isqrt_round_tb_top;
  import isqrt_pkg::*;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic        s_iv, s_ir, s_ov;
  logic [15:0] s_op;
  logic [8:0]  s_root;
  logic        p_iv, p_ir, p_ov;
  logic [47:0] p_op;
  logic [24:0] p_root;

  isqrt_round #(.OP_W(16), .ARCH(ARCH_SEQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir),
    .in_op(s_op), .out_valid(s_ov), .root_o(s_root)
  );

  isqrt_round #(.OP_W(48), .ARCH(ARCH_PIPE)) dut_pipe_i (
    .clk(clk), .rst_n(rst_n), .in_valid(p_iv), .in_ready(p_ir),
    .in_op(p_op), .out_valid(p_ov), .root_o(p_root)
  );

  function automatic longint unsigned ref_root(input longint unsigned x);
    longint unsigned r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t * t <= x) r = t;
    end
    if (x - r * r > r) r = r + 1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one sequential operation; poke drives junk while busy (R7)
  task automatic seq_op(input logic [15:0] x, input bit poke);
    longint unsigned e = ref_root(64'(x));
    chk(s_ir == 1'b1, "R6 ready when idle", 64'(s_ir), 1);
    s_iv = 1'b1;
    s_op = x;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk(s_ov == 1'b0, "R4 no early result", 64'(s_ov), 0);
      chk(s_ir == 1'b0, "R6 ready low while busy", 64'(s_ir), 0);
      s_iv = poke && (k < 7);
      s_op = ~x;
      @(posedge clk);
      @(negedge clk);
    end
    s_iv = 1'b0;
    chk(s_ov == 1'b1, "R4 result after N+1 edges", 64'(s_ov), 1);
    chk(64'(s_root) == e, poke ? "R7 R1 root with busy pokes" : "R1 rounded root",
        64'(s_root), e);
    chk(s_ir == 1'b1, "R6 ready in result cycle", 64'(s_ir), 1);
    @(posedge clk);
    @(negedge clk);
    chk(s_ov == 1'b0, "R6 R7 single result pulse", 64'(s_ov), 0);
  endtask

  localparam int PL   = 70;
  localparam int PLAT = 25;
  logic        pv [0:PL-1];
  logic [47:0] px [0:PL-1];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : main
    int unused_seed;
    logic [47:0] k24;
    checks = 0;
    errors = 0;
    unused_seed = $urandom(32'h5eed);
    rst_n = 1'b0;
    s_iv = 1'b0; s_op = '0;
    p_iv = 1'b0; p_op = '0;
    repeat (3) @(negedge clk);
    chk(s_ov == 1'b0, "R8 seq valid clear in reset", 64'(s_ov), 0);
    chk(p_ov == 1'b0, "R8 pipe valid clear in reset", 64'(p_ov), 0);
    chk(s_ir == 1'b1, "R8 seq idle in reset", 64'(s_ir), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // sequential directed corners
    seq_op(16'd0, 1'b0);      // R2
    seq_op(16'd1, 1'b0);      // R2
    seq_op(16'd2, 1'b0);      // R2
    seq_op(16'd3, 1'b1);      // R2
    seq_op(16'd4, 1'b0);      // R2
    seq_op(16'd12, 1'b0);     // R9 3*3+3
    seq_op(16'd13, 1'b1);     // R9
    seq_op(16'd65280, 1'b0);  // R9 255*255+255 -> 255
    seq_op(16'd65281, 1'b0);  // R9 -> 256
    seq_op(16'hFFFF, 1'b1);   // R3 -> 256
    chk(s_root == 9'd256, "R3 seq all-ones", 64'(s_root), 256);
    for (int i = 0; i < 40; i++) seq_op(16'($urandom), i[0]);

    // R8 reset in the middle of a computation
    s_iv = 1'b1; s_op = 16'd1000;
    @(posedge clk);
    @(negedge clk);
    s_iv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(s_ir == 1'b1, "R8 reset aborts busy", 64'(s_ir), 1);
    chk(s_ov == 1'b0, "R8 reset clears valid", 64'(s_ov), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(s_ov == 1'b0, "R8 abandoned op yields nothing", 64'(s_ov), 0);
    end

    // pipelined stream
    k24 = 48'd16777215;
    for (int i = 0; i < PL; i++) begin
      pv[i] = ($urandom % 4) != 0;
      px[i] = {16'($urandom), 32'($urandom)};
    end
    pv[0] = 1'b1; px[0] = 48'd0;
    pv[1] = 1'b1; px[1] = 48'd1;
    pv[2] = 1'b1; px[2] = 48'd3;
    pv[3] = 1'b1; px[3] = 48'hFFFF_FFFF_FFFF;
    pv[4] = 1'b1; px[4] = k24 * k24 + k24;
    pv[5] = 1'b1; px[5] = k24 * k24 + k24 + 48'd1;
    pv[6] = 1'b0;
    pv[7] = 1'b1; px[7] = 48'd42;
    for (int c = 0; c < PL + PLAT + 1; c++) begin
      chk(p_ir == 1'b1, "R5 pipe always ready", 64'(p_ir), 1);
      if (c >= PLAT) begin
        chk(p_ov == pv[c-PLAT], "R4 R5 pipe valid timing", 64'(p_ov), 64'(pv[c-PLAT]));
        if (pv[c-PLAT] && p_ov)
          chk(64'(p_root) == ref_root(64'(px[c-PLAT])), "R1 R9 pipe root",
              64'(p_root), ref_root(64'(px[c-PLAT])));
        if (c - PLAT == 3)
          chk(p_root == 25'd16777216, "R3 pipe all-ones", 64'(p_root), 16777216);
      end else begin
        chk(p_ov == 1'b0, "R4 pipe no early result", 64'(p_ov), 0);
      end
      p_iv = (c < PL) ? pv[c] : 1'b0;
      p_op = (c < PL) ? px[c] : 48'd0;
      @(posedge clk);
      @(negedge clk);
    end
    finish_run();
  end
endmodule